// File: doc/BRIEF.md
# Dual-Bus Ready Synchronizer

This block merges the transfer-complete indications of several buses into the single ready line a processor samples before it ends a bus cycle. Each bus supplies an active-high ready and an active-low enable. A bus's ready counts only while that bus's enable is low. The counted readies are ORed together. The merged value is then retimed to the system clock before it reaches the processor.

A mode input picks the retiming depth. When the mode line is high, and it idles high when nothing drives it, the merged ready is captured on the falling clock edge only. When the mode line is low, a rising ready must first be seen on a rising edge and is then confirmed on the next falling edge. This gives an extra half cycle of settling for sources that are not synchronous to the clock. A falling ready always skips the rising-edge stage and removes READY at the next falling edge. This prevents wait states from being lost. The mode may change from one bus cycle to the next, and the value present at each falling edge governs that edge.

Top module: `rsync_dual_ready`

## Requirements
- R1: Bus k (bit k of `rdy_in` paired with bit k of `en_n`; bit 0 is the first bus, bit 1 the second) contributes to the merged ready only while its `en_n` bit is 0. The merged ready is the OR of all contributions. A bus whose `en_n` bit is 1 has no effect on `ready_out`.
- R2: With `single_stage` = 1, `ready_out` takes the merged ready value present at each falling clock edge.
- R3: With `single_stage` = 0, `ready_out` goes high at a falling edge only if the merged ready is high at that falling edge and was also high at the preceding rising edge.
- R4: When the merged ready is low at a falling edge, `ready_out` is low after that edge, in either mode.
- R5: `ready_out` changes only at falling clock edges or on reset. A change of the inputs between a falling edge and the next rising edge leaves it unchanged until the next falling edge.
- R6: `single_stage` may change on every clock cycle. The value present at a falling edge selects the behaviour of that edge.
- R7: `rst` (active high, asynchronous) forces `ready_out` low at once. It also clears the rising-edge stage, so the first two-stage assertion after reset needs a fresh rising-edge capture.
- R8: A merged-ready pulse that is absent at the falling edge leaves `ready_out` low. This holds in single-stage mode for a pulse between edges, and in two-stage mode for a pulse that covers only the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rising edge feeds the first stage, falling edge the output stage |
| rst | input | 1 | Active-high asynchronous processor reset |
| rdy_in | input | NUM_BUS | Per-bus transfer-complete indications, active high |
| en_n | input | NUM_BUS | Per-bus qualifying enables, active low |
| single_stage | input | 1 | 1 selects one falling-edge stage, 0 selects two stages for rising ready |
| ready_out | output | 1 | Retimed, merged ready to the processor |

## Verification
The properties assume that `rdy_in`, `en_n` and `single_stage` are stable across each clock edge. They take for granted the setup and hold margins that are outside this block's scope. They also assume that reset does not rise exactly on a clock edge. The stimulus moves its input edges to offsets of one to four time units after a rising edge, or a few units after a falling edge. It never changes an input on an edge, yet it still covers arrivals in both clock phases and the cycle in which `ready_out` answers each one.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
   // Upper bound on buses the merge tree is sized for
   localparam int unsigned RSYNC_MAX_BUS = 8;

   // Encoding of the depth-select input
   typedef enum logic {
      RSYNC_TWO_STAGE = 1'b0,
      RSYNC_ONE_STAGE = 1'b1
   } rsync_depth_e;

   // Level the output takes while reset is applied
   localparam logic RSYNC_IDLE = 1'b0;
endpackage : rsync_pkg

// File: rtl/rsync_qualify.sv
module rsync_qualify #(
   parameter int unsigned NUM_BUS = 2
) (
   input  logic [NUM_BUS-1:0] rdy_in,
   input  logic [NUM_BUS-1:0] en_n,
   output logic               merged
);
   logic [NUM_BUS-1:0] granted;

   // Each bus contributes only under its own low-active enable
   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      assign granted[b] = rdy_in[b] & ~en_n[b];
   end

   assign merged = |granted;
endmodule : rsync_qualify

// File: rtl/rsync_rise_stage.sv
module rsync_rise_stage
   import rsync_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) q <= RSYNC_IDLE;
      else     q <= d;
   end
endmodule : rsync_rise_stage

// File: rtl/rsync_fall_stage.sv
module rsync_fall_stage
   import rsync_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic merged,
   input  logic early_q,
   input  logic depth_sel,
   output logic q
);
   logic d_next;

   // Rising ready in two-stage mode needs the earlier capture as well;
   // a low merged value always passes straight through.
   always_comb begin
      if (rsync_depth_e'(depth_sel) == RSYNC_ONE_STAGE) d_next = merged;
      else                                              d_next = merged & early_q;
   end

   always_ff @(negedge clk or posedge rst) begin
      if (rst) q <= RSYNC_IDLE;
      else     q <= d_next;
   end
endmodule : rsync_fall_stage

// File: rtl/rsync_dual_ready.sv
module rsync_dual_ready
   import rsync_pkg::*;
#(
   parameter int unsigned NUM_BUS = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_BUS-1:0] rdy_in,
   input  logic [NUM_BUS-1:0] en_n,
   input  logic               single_stage,
   output logic               ready_out
);
   localparam bit BUS_OK = (NUM_BUS >= 1) && (NUM_BUS <= RSYNC_MAX_BUS);

   if (!BUS_OK) begin : g_bad_bus
      $error("rsync_dual_ready: NUM_BUS out of range");
   end

   logic merged;
   logic first_q;

   rsync_qualify #(.NUM_BUS(NUM_BUS)) u_qual (
      .rdy_in (rdy_in),
      .en_n   (en_n),
      .merged (merged)
   );

   rsync_rise_stage u_rise (
      .clk (clk),
      .rst (rst),
      .d   (merged),
      .q   (first_q)
   );

   rsync_fall_stage u_fall (
      .clk       (clk),
      .rst       (rst),
      .merged    (merged),
      .early_q   (first_q),
      .depth_sel (single_stage),
      .q         (ready_out)
   );
endmodule : rsync_dual_ready

// File: rtl/rsync_dual_ready_chk.sv
module rsync_dual_ready_chk #(
   parameter int unsigned NUM_BUS = 2
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_BUS-1:0] rdy_in,
   input logic [NUM_BUS-1:0] en_n,
   input logic               single_stage,
   input logic               ready_out,
   input logic               first_q
);
   logic seen;
   assign seen = |(rdy_in & ~en_n);

   // R2: one-stage mode passes a high merged ready at the falling edge
   a_r2_one_stage_follow: assert property (@(negedge clk) disable iff (rst)
      (single_stage && seen) |=> ready_out);

   // R4 / R1: no enabled ready at a falling edge removes the output
   a_r4_fast_drop: assert property (@(negedge clk) disable iff (rst)
      !seen |=> !ready_out);

   // R3: two-stage mode holds off until the rising-edge stage has seen ready
   a_r3_hold_off: assert property (@(negedge clk) disable iff (rst)
      (!single_stage && !first_q) |=> !ready_out);

   // R3: both stages high lets ready through
   a_r3_two_stage_pass: assert property (@(negedge clk) disable iff (rst)
      (!single_stage && seen && first_q) |=> ready_out);

   // R7: reset keeps both stages cleared
   a_r7_reset_clear: assert property (@(posedge clk)
      rst |-> (!ready_out && !first_q));
endmodule : rsync_dual_ready_chk

bind rsync_dual_ready rsync_dual_ready_chk #(.NUM_BUS(NUM_BUS)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .rdy_in       (rdy_in),
   .en_n         (en_n),
   .single_stage (single_stage),
   .ready_out    (ready_out),
   .first_q      (first_q)
);

// File: tb/tb_rsync_dual_ready.sv
module tb_rsync_dual_ready;
   localparam int PERIOD = 10;
   localparam int NB     = 2;
   localparam int NVEC   = 14;

   // {rdy_in[1:0], en_n[1:0], single_stage, expected ready}
   localparam logic [5:0] VEC [NVEC] = '{
      6'b01_10_1_1, 6'b01_11_1_0, 6'b10_01_0_0, 6'b10_01_0_1,
      6'b10_10_0_0, 6'b11_11_1_0, 6'b00_00_1_0, 6'b11_00_0_0,
      6'b11_00_1_1, 6'b01_01_0_0, 6'b10_01_0_0, 6'b01_10_0_1,
      6'b01_10_1_1, 6'b00_10_0_0
   };

   logic          clk = 1'b0;
   logic          rst = 1'b0;
   logic [NB-1:0] rdy_in = '0;
   logic [NB-1:0] en_n = '1;
   logic          single_stage = 1'b1;   // idles high like an open line
   logic          ready_out;
   int            total = 0;
   int            bad = 0;

   rsync_dual_ready #(.NUM_BUS(NB)) dut (
      .clk          (clk),
      .rst          (rst),
      .rdy_in       (rdy_in),
      .en_n         (en_n),
      .single_stage (single_stage),
      .ready_out    (ready_out)
   );

   always #(PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #(PERIOD*5000);
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      #3;
      chk("R7 reset level", ready_out, 1'b0);
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      repeat (2) @(posedge clk);

      // Vector walk: inputs move 1..4 units after a rising edge, result
      // read just after the following falling edge.
      for (int i = 0; i < NVEC; i++) begin
         @(posedge clk);
         #(1 + i % 4);
         rdy_in       = VEC[i][5:4];
         en_n         = VEC[i][3:2];
         single_stage = VEC[i][1];
         #(5 - (i % 4));
         chk($sformatf("R1 R2 R3 R4 R6 vector %0d", i), ready_out, VEC[i][0]);
      end

      // R3/R5: rising ready arriving after a falling edge, two-stage mode
      @(posedge clk);
      #7;
      single_stage = 1'b0; rdy_in = 2'b01; en_n = 2'b10;
      #4 chk("R5 no change at rising edge", ready_out, 1'b0);
      #5 chk("R3 late arrival passes", ready_out, 1'b1);

      // R4/R5: deassertion arriving after a falling edge
      #1 rdy_in = 2'b00;
      #4 chk("R5 hold until falling edge", ready_out, 1'b1);
      #5 chk("R4 drop at falling edge", ready_out, 1'b0);

      // R8: short pulse between edges in one-stage mode
      @(posedge clk);
      #1 single_stage = 1'b1; rdy_in = 2'b01;
      #2 rdy_in = 2'b00;
      #3 chk("R8 pulse between edges", ready_out, 1'b0);

      // R8: pulse covering only the rising edge in two-stage mode
      single_stage = 1'b0;
      #2 rdy_in = 2'b01;
      #4 rdy_in = 2'b00;
      #4 chk("R8 rising-edge-only pulse", ready_out, 1'b0);

      // R7: reset mid-run, then first-stage clear seen afterwards
      single_stage = 1'b1; rdy_in = 2'b01;
      #10 chk("R2 ready before reset", ready_out, 1'b1);
      #1 rst = 1'b1;
      #1 chk("R7 immediate clear", ready_out, 1'b0);
      #10 chk("R7 held across falling edge", ready_out, 1'b0);
      #3 single_stage = 1'b0; rst = 1'b0;
      #5 chk("R7 first stage cleared", ready_out, 1'b0);
      #10 chk("R3 after fresh capture", ready_out, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule : tb_rsync_dual_ready